// File: doc/BRIEF.md
# Control Sub-packet Register Executor

This block consumes the payload of one transport packet at a time, presented as a stream of 32-bit words with start and end flags, the packet's channel number and the total payload length in bytes. When the channel marks the packet as a control packet, the block walks the word-aligned sub-packets in the payload and applies their register-write commands to a local register file. Packets on any other channel pass by without effect.

Each sub-packet opens with a header word holding an opcode, an argument byte count and a register number. Two commands are executed: a full-register write and a bit-masked write. For the masked write, only the register bits whose mask bit is 1 take the new value. Every other opcode is stepped over using its declared length, so the parser stays aligned with the sub-packets that follow. The register file has a combinational read port for the surrounding logic.

Top module: `ctrl_subpkt_exec`

## Requirements
- R1: Only a packet whose start word arrives with channel 0x1f is parsed. A packet on any other channel leaves every register unchanged.
- R2: In a header word, the opcode is bits 31:24, the argument byte count L is bits 23:16 and the register number is bits 15:0. The next header is the word ceil((L+2)/4) words after the current one.
- R3: Opcode 0x03 with L of at least 6 writes the following word into the whole register. The write takes effect at the clock edge that accepts that word, and the read port shows the new value after that edge.
- R4: Opcode 0x04 with L of at least 10 takes a value word and then a mask word. The register becomes (old & ~mask) | (value & mask).
- R5: An unknown opcode, or opcode 0x03 or 0x04 with L too short for its arguments, causes no write. Its words are skipped according to L.
- R6: A register number of 32 or more causes no write. Its low bits do not alias a lower register, and parsing of later sub-packets continues.
- R7: If a header's L+2 exceeds the payload bytes that remain, that sub-packet and every later word of the packet are ignored.
- R8: Parsing ends once fewer than 2 payload bytes remain, even if more words arrive before the end flag. A cycle with valid low is not a word.
- R9: After reset, every register reads zero.
- R10: After a word flagged last, words without a start flag are ignored. A start flag always restarts parsing, which drops any unfinished sub-packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A payload word is present this cycle |
| sop_i | input | 1 | First word of a packet |
| eop_i | input | 1 | Last word of a packet |
| chan_i | input | 5 | Channel number of the packet, sampled with sop_i |
| bcnt_i | input | 9 | Payload length in bytes, sampled with sop_i |
| word_i | input | 32 | Payload word |
| rd_addr_i | input | 5 | Register file read address |
| rd_data_o | output | 32 | Register file read data, combinational |

## Verification
The bench uses the default parameters: 32 registers, a 9-bit byte count, the control channel at 0x1f, and opcodes 0x03 and 0x04. With 32 registers, register numbers 32 and 0x0120 are out of range but share their low five bits with register 0, so any aliasing shows up as a change in register 0. The 9-bit byte count lets a payload end in the middle of a header, or be shorter than a header's declared length, which makes the early-stop paths reachable.

// File: rtl/ctrl_subpkt_pkg.sv
package ctrl_subpkt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_BODY,
    ST_DROP
  } walk_st_e;

  typedef enum logic [1:0] {
    OPK_SKIP,
    OPK_WR,
    OPK_WRM
  } op_kind_e;

  localparam int unsigned OPC_MSB = 31;
  localparam int unsigned OPC_LSB = 24;
  localparam int unsigned LEN_MSB = 23;
  localparam int unsigned LEN_LSB = 16;
  localparam int unsigned NUM_MSB = 15;
  localparam int unsigned NUM_LSB = 0;
endpackage

// File: rtl/subpkt_hdr_dec.sv
module subpkt_hdr_dec
  import ctrl_subpkt_pkg::*;
#(
  parameter int unsigned BCNT_W   = 9,
  parameter int unsigned NUM_REGS = 32,
  parameter logic [7:0]  OP_WR    = 8'h03,
  parameter logic [7:0]  OP_WRM   = 8'h04,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned CW      = ((BCNT_W > 9) ? BCNT_W : 9) + 1
) (
  input  logic [31:0]       word_i,
  input  logic [BCNT_W-1:0] avail_i,
  output logic              fits_o,
  output logic [CW-1:0]     nwords_o,
  output logic [BCNT_W-1:0] left_o,
  output op_kind_e          kind_o,
  output logic              reg_ok_o,
  output logic [AW-1:0]     reg_idx_o
);
  logic [7:0]    op;
  logic [7:0]    len;
  logic [15:0]   num;
  logic [CW-1:0] need, span, availx;

  assign op  = word_i[OPC_MSB:OPC_LSB];
  assign len = word_i[LEN_MSB:LEN_LSB];
  assign num = word_i[NUM_MSB:NUM_LSB];

  always_comb begin
    availx   = CW'(avail_i);
    need     = CW'(len) + CW'(2);
    nwords_o = (need + CW'(3)) >> 2;
    span     = nwords_o << 2;
    fits_o   = (availx >= CW'(2)) && (need <= availx);
    left_o   = (availx > span) ? BCNT_W'(availx - span) : '0;
  end

  always_comb begin
    if (op == OP_WR && len >= 8'd6)        kind_o = OPK_WR;
    else if (op == OP_WRM && len >= 8'd10) kind_o = OPK_WRM;
    else                                   kind_o = OPK_SKIP;
  end

  assign reg_ok_o  = {16'b0, num} < 32'(NUM_REGS);
  assign reg_idx_o = num[AW-1:0];
endmodule

// File: rtl/subpkt_walker.sv
module subpkt_walker
  import ctrl_subpkt_pkg::*;
#(
  parameter int unsigned BCNT_W   = 9,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned CW      = ((BCNT_W > 9) ? BCNT_W : 9) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic              is_ctrl_i,
  input  logic [31:0]       word_i,
  input  logic              fits_i,
  input  logic [CW-1:0]     nwords_i,
  input  logic [BCNT_W-1:0] left_i,
  input  op_kind_e          kind_i,
  input  logic              reg_ok_i,
  input  logic [AW-1:0]     reg_idx_i,
  output logic              hdr_now_o,
  output logic [BCNT_W-1:0] bytes_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [31:0]       wdata_o,
  output logic [31:0]       wmask_o
);
  walk_st_e          st_q;
  op_kind_e          kind_q;
  logic [BCNT_W-1:0] bytes_q;
  logic [CW-1:0]     rem_q;
  logic [AW-1:0]     reg_q;
  logic              reg_ok_q;
  logic [1:0]        idx_q;
  logic [31:0]       val_q;
  logic              body_now;

  assign hdr_now_o = valid_i && ((sop_i && is_ctrl_i) || (!sop_i && st_q == ST_HDR));
  assign body_now  = valid_i && !sop_i && st_q == ST_BODY;
  assign bytes_o   = bytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      kind_q   <= OPK_SKIP;
      bytes_q  <= '0;
      rem_q    <= '0;
      reg_q    <= '0;
      reg_ok_q <= 1'b0;
      idx_q    <= '0;
      val_q    <= '0;
    end else if (valid_i) begin
      if (sop_i && !is_ctrl_i) begin
        st_q <= ST_DROP;
      end else if (hdr_now_o) begin
        if (!fits_i) begin
          st_q <= ST_DROP;
        end else begin
          bytes_q  <= left_i;
          rem_q    <= nwords_i - CW'(1);
          kind_q   <= kind_i;
          reg_ok_q <= reg_ok_i;
          reg_q    <= reg_idx_i;
          idx_q    <= '0;
          if (nwords_i == CW'(1)) st_q <= (left_i < BCNT_W'(2)) ? ST_DROP : ST_HDR;
          else                    st_q <= ST_BODY;
        end
      end else if (body_now) begin
        if (idx_q == 2'd0) val_q <= word_i;
        if (idx_q != 2'd3) idx_q <= idx_q + 2'd1;
        rem_q <= rem_q - CW'(1);
        if (rem_q == CW'(1)) st_q <= (bytes_q < BCNT_W'(2)) ? ST_DROP : ST_HDR;
      end
      if (eop_i) st_q <= ST_IDLE;
    end
  end

  // value lands on word 0 for plain write, mask word 1 completes masked write
  assign we_o = body_now && reg_ok_q &&
                ((kind_q == OPK_WR && idx_q == 2'd0) || (kind_q == OPK_WRM && idx_q == 2'd1));
  assign waddr_o = reg_q;
  assign wdata_o = (kind_q == OPK_WRM) ? val_q : word_i;
  assign wmask_o = (kind_q == OPK_WRM) ? word_i : '1;
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] wmask_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))
        regs_q[g] <= (regs_q[g] & ~wmask_i) | (wdata_i & wmask_i);
    end
  end

  assign rd_data_o = (32'(rd_addr_i) < NUM_REGS) ? regs_q[rd_addr_i] : '0;
endmodule

// File: rtl/ctrl_subpkt_exec.sv
module ctrl_subpkt_exec
  import ctrl_subpkt_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned BCNT_W    = 9,
  parameter int unsigned CHAN_W    = 5,
  parameter logic [4:0]  CTRL_CHAN = 5'h1f,
  parameter logic [7:0]  OP_WR     = 8'h03,
  parameter logic [7:0]  OP_WRM    = 8'h04,
  localparam int unsigned AW       = $clog2(NUM_REGS),
  localparam int unsigned CW       = ((BCNT_W > 9) ? BCNT_W : 9) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [BCNT_W-1:0] bcnt_i,
  input  logic [31:0]       word_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [31:0]       rd_data_o
);
  logic              is_ctrl, fits, reg_ok, hdr_now;
  logic [CW-1:0]     nwords;
  logic [BCNT_W-1:0] left, bytes_q, avail;
  op_kind_e          kind;
  logic [AW-1:0]     reg_idx;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [31:0]       wr_data, wr_mask;

  assign is_ctrl = chan_i == CHAN_W'(CTRL_CHAN);
  assign avail   = sop_i ? bcnt_i : bytes_q;

  subpkt_hdr_dec #(
    .BCNT_W(BCNT_W), .NUM_REGS(NUM_REGS), .OP_WR(OP_WR), .OP_WRM(OP_WRM)
  ) u_dec (
    .word_i   (word_i),
    .avail_i  (avail),
    .fits_o   (fits),
    .nwords_o (nwords),
    .left_o   (left),
    .kind_o   (kind),
    .reg_ok_o (reg_ok),
    .reg_idx_o(reg_idx)
  );

  subpkt_walker #(
    .BCNT_W(BCNT_W), .NUM_REGS(NUM_REGS)
  ) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .sop_i    (sop_i),
    .eop_i    (eop_i),
    .is_ctrl_i(is_ctrl),
    .word_i   (word_i),
    .fits_i   (fits),
    .nwords_i (nwords),
    .left_i   (left),
    .kind_i   (kind),
    .reg_ok_i (reg_ok),
    .reg_idx_i(reg_idx),
    .hdr_now_o(hdr_now),
    .bytes_o  (bytes_q),
    .we_o     (wr_en),
    .waddr_o  (wr_addr),
    .wdata_o  (wr_data),
    .wmask_o  (wr_mask)
  );

  ctrl_reg_bank #(
    .NUM_REGS(NUM_REGS), .DATA_W(32)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .waddr_i  (wr_addr),
    .wdata_i  (wr_data),
    .wmask_i  (wr_mask),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/ctrl_subpkt_exec_chk.sv
module ctrl_subpkt_exec_chk #(
  parameter int unsigned CHAN_W    = 5,
  parameter logic [4:0]  CTRL_CHAN = 5'h1f,
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned AW        = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              sop_i,
  input logic              eop_i,
  input logic [CHAN_W-1:0] chan_i,
  input logic              hdr_i,
  input logic              we_i,
  input logic [AW-1:0]     waddr_i
);
  logic in_data_q;
  logic data_sop;

  assign data_sop = valid_i && sop_i && chan_i != CHAN_W'(CTRL_CHAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_data_q <= 1'b0;
    else if (valid_i && (eop_i || sop_i)) in_data_q <= data_sop && !eop_i;
  end

  a_r1_data_sop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_sop |-> !we_i);

  a_r1_data_pkt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_data_q |-> !we_i);

  a_r6_addr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < NUM_REGS));

  a_r8_no_word_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !we_i);

  a_r10_after_last_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eop_i) |=> !(we_i && !sop_i));

  a_r2_hdr_not_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_i |-> !we_i);
endmodule

bind ctrl_subpkt_exec ctrl_subpkt_exec_chk #(
  .CHAN_W(CHAN_W), .CTRL_CHAN(CTRL_CHAN), .NUM_REGS(NUM_REGS), .AW(AW)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .sop_i  (sop_i),
  .eop_i  (eop_i),
  .chan_i (chan_i),
  .hdr_i  (hdr_now),
  .we_i   (wr_en),
  .waddr_i(wr_addr)
);

// File: tb/tb_ctrl_subpkt_exec.sv
module tb_ctrl_subpkt_exec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sop_i = 1'b0, eop_i = 1'b0;
  logic [4:0]  chan_i = '0;
  logic [8:0]  bcnt_i = '0;
  logic [31:0] word_i = '0;
  logic [4:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q [32];
  logic [31:0] pkt [16];

  always #2.5 clk_i = ~clk_i;

  ctrl_subpkt_exec dut (.*);

  function automatic logic [31:0] hdr(input logic [7:0] op, input logic [7:0] len,
                                      input logic [15:0] num);
    return {op, len, num};
  endfunction

  task automatic send(input logic [4:0] ch, input int bytes, input int n,
                      input bit do_sop, input bit do_eop, input int gap_at);
    for (int i = 0; i < n; i++) begin
      if (gap_at == i) begin
        @(negedge clk_i);
        valid_i = 1'b0; sop_i = 1'b0; eop_i = 1'b0; word_i = 32'hFFFF_FFFF;
      end
      @(negedge clk_i);
      valid_i = 1'b1;
      sop_i   = do_sop && i == 0;
      eop_i   = do_eop && i == n - 1;
      chan_i  = ch;
      bcnt_i  = 9'(bytes);
      word_i  = pkt[i];
    end
    @(negedge clk_i);
    valid_i = 1'b0; sop_i = 1'b0; eop_i = 1'b0; word_i = '0;
  endtask

  task automatic check_reg(input int a, input string tag);
    rd_addr_i = 5'(a);
    #1;
    n_chk++;
    if (rd_data_o !== exp_q[a]) begin
      n_fail++;
      $display("FAIL %s reg %0d actual %h expected %h", tag, a, rd_data_o, exp_q[a]);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 32; a++) check_reg(a, tag);
  endtask

  task automatic t_reset;
    check_all("R9");
  endtask

  task automatic t_plain;
    pkt[0] = hdr(8'h03, 8'd6, 16'd5); pkt[1] = 32'hDEAD_BEEF;
    exp_q[5] = 32'hDEAD_BEEF;
    send(5'h1f, 8, 2, 1, 1, -1);
    check_reg(5, "R3");
    check_all("R3");
  endtask

  task automatic t_masked;
    pkt[0] = hdr(8'h04, 8'd10, 16'd5); pkt[1] = 32'h1234_5678; pkt[2] = 32'h0000_FFFF;
    exp_q[5] = 32'hDEAD_5678;
    send(5'h1f, 12, 3, 1, 1, 1); // idle cycle inside packet, R8
    check_reg(5, "R4");
    check_all("R4");
  endtask

  task automatic t_unknown;
    pkt[0] = hdr(8'h7A, 8'd5, 16'd0); pkt[1] = hdr(8'h03, 8'd6, 16'd9);
    pkt[2] = hdr(8'h03, 8'd6, 16'd7); pkt[3] = 32'hA5A5_A5A5;
    exp_q[7] = 32'hA5A5_A5A5;
    send(5'h1f, 16, 4, 1, 1, -1);
    check_reg(9, "R5");
    check_all("R5");
  endtask

  task automatic t_multi;
    pkt[0] = hdr(8'h55, 8'd2, 16'd0);
    pkt[1] = hdr(8'h03, 8'd6, 16'd1);  pkt[2] = 32'h1111_1111;
    pkt[3] = hdr(8'h04, 8'd10, 16'd2); pkt[4] = 32'hFFFF_FFFF; pkt[5] = 32'h00F0_F000;
    pkt[6] = hdr(8'h03, 8'd6, 16'd3);  pkt[7] = 32'h3333_3333;
    exp_q[1] = 32'h1111_1111; exp_q[2] = 32'h00F0_F000; exp_q[3] = 32'h3333_3333;
    send(5'h1f, 32, 8, 1, 1, -1);
    check_all("R2");
  endtask

  task automatic t_short;
    pkt[0] = hdr(8'h03, 8'd2, 16'd4);
    pkt[1] = hdr(8'h04, 8'd6, 16'd8); pkt[2] = 32'hFFFF_FFFF;
    pkt[3] = hdr(8'h03, 8'd6, 16'd6); pkt[4] = 32'h6666_6666;
    exp_q[6] = 32'h6666_6666;
    send(5'h1f, 20, 5, 1, 1, -1);
    check_reg(4, "R5");
    check_reg(8, "R5");
    check_all("R5");
  endtask

  task automatic t_range;
    pkt[0] = hdr(8'h03, 8'd6, 16'd32);     pkt[1] = 32'h7777_7777;
    pkt[2] = hdr(8'h03, 8'd6, 16'h0120);   pkt[3] = 32'h8888_8888;
    pkt[4] = hdr(8'h03, 8'd6, 16'd10);     pkt[5] = 32'hAAAA_0000;
    exp_q[10] = 32'hAAAA_0000;
    send(5'h1f, 24, 6, 1, 1, -1);
    check_reg(0, "R6");
    check_all("R6");
  endtask

  task automatic t_overrun;
    pkt[0] = hdr(8'h03, 8'd6, 16'd11);  pkt[1] = 32'hBBBB_BBBB;
    pkt[2] = hdr(8'h04, 8'd10, 16'd12); pkt[3] = 32'hFFFF_FFFF; pkt[4] = 32'hFFFF_FFFF;
    pkt[5] = hdr(8'h03, 8'd6, 16'd13);  pkt[6] = 32'h1313_1313;
    exp_q[11] = 32'hBBBB_BBBB;
    send(5'h1f, 12, 7, 1, 1, -1);
    check_reg(12, "R7");
    check_reg(13, "R7");
    check_all("R7");
  endtask

  task automatic t_data_chan;
    pkt[0] = hdr(8'h03, 8'd6, 16'd14); pkt[1] = 32'hCCCC_CCCC;
    send(5'h00, 8, 2, 1, 1, -1);
    send(5'h1e, 8, 2, 1, 1, -1);
    check_reg(14, "R1");
    check_all("R1");
  endtask

  task automatic t_end_count;
    pkt[0] = hdr(8'h03, 8'd6, 16'd15); pkt[1] = 32'h1515_1515;
    pkt[2] = hdr(8'h03, 8'd6, 16'd16); pkt[3] = 32'h1616_1616;
    exp_q[15] = 32'h1515_1515;
    send(5'h1f, 8, 4, 1, 1, -1);
    check_reg(16, "R8");
    check_all("R8");
  endtask

  task automatic t_restart;
    pkt[0] = hdr(8'h03, 8'd6, 16'd17); pkt[1] = 32'h1717_1717;
    send(5'h1f, 8, 2, 0, 1, -1); // no start flag after last word
    check_reg(17, "R10");
    pkt[0] = hdr(8'h04, 8'd10, 16'd18); pkt[1] = 32'hFFFF_FFFF;
    send(5'h1f, 12, 2, 1, 0, -1); // cut short by next start
    pkt[0] = hdr(8'h03, 8'd6, 16'd19); pkt[1] = 32'h1919_1919;
    exp_q[19] = 32'h1919_1919;
    send(5'h1f, 8, 2, 1, 1, -1);
    check_reg(18, "R10");
    check_reg(19, "R10");
    check_all("R10");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) exp_q[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_plain();
    t_masked();
    t_unknown();
    t_multi();
    t_short();
    t_range();
    t_overrun();
    t_data_chan();
    t_end_count();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule